// File: doc/BRIEF.md
# Pad-ring connectivity tester with AND-tree test output

This block sits between the core logic and the pad ring. It gives boards a way to find pins that are open or badly soldered without running any functional traffic. An active-low test-enable input selects between two modes.

In normal operation, core output data and output enables pass straight to the pads, and the shared memory-access/test-out pad carries the memory-access indication from the core. While the test-enable input is held low, three things change. Every output and bidirectional pad enable is forced off, so those pads are tri-stated. The per-pad weak pull-up enables are asserted. The values read back from every covered pad are combined in a single AND tree, and the result drives the shared pad.

A tester drives one pin low at a time. If that pin is attached, the shared pad follows it low. With every covered pin left floating on its pull-up, the shared pad reads high. The external bus control and data pads are outside the covered set. Their read-back values pass to the core, but they never reach the AND tree.

The mode is held in an enumerated value with two states. MODE_FUNC is active while `test_en_n` is high. MODE_CONN is active while `test_en_n` is low. There are two transitions: enter-test, on the falling edge of `test_en_n`, and leave-test, on its rising edge. Both act at once, with no register in any path.

Top module: `pad_conn_test`

## Requirements
- R1: The block is in MODE_CONN whenever `test_en_n` is 0 and in MODE_FUNC whenever it is 1; a change of `test_en_n` takes effect combinationally.
- R2: In MODE_CONN every bit of `pad_oe` is 0, whatever the value of `core_oe`.
- R3: In MODE_FUNC `pad_oe` equals `core_oe`; in both modes `pad_do` equals `core_do`.
- R4: Every bit of `pad_pu` is 1 in MODE_CONN and 0 in MODE_FUNC.
- R5: In MODE_CONN `mac_tout` is the AND of all bits of `pad_di_in` and `pad_di_io`; with all of these bits at 1 it is 1.
- R6: In MODE_CONN, driving any single covered pad input to 0 while all others are 1 makes `mac_tout` 0.
- R7: `xpad_di` (the excluded bus pads) never affects `mac_tout`, and `xcore_di` always equals `xpad_di`.
- R8: In MODE_FUNC `mac_tout` equals `mem_sel` (1 marks a local-memory access, 0 a system-memory access), independent of all pad inputs.
- R9: In both modes `core_di_in` equals `pad_di_in` and `core_di_io` equals `pad_di_io`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_en_n | input | 1 | Active-low connectivity test enable |
| mem_sel | input | 1 | Core memory-access indication, 1 = local, 0 = system |
| core_do | input | NUM_IO | Core output data for output and bidirectional pads |
| core_oe | input | NUM_IO | Core output enables for the same pads |
| pad_di_in | input | NUM_IN | Values read from input-only covered pads |
| pad_di_io | input | NUM_IO | Values read back from output and bidirectional pads |
| xpad_di | input | NUM_XPAD | Values read from the excluded bus pads |
| pad_do | output | NUM_IO | Data to output and bidirectional pads |
| pad_oe | output | NUM_IO | Output enables to output and bidirectional pads |
| pad_pu | output | NUM_IN+NUM_IO | Weak pull-up enables for covered pads, inputs first |
| core_di_in | output | NUM_IN | Input-only pad values passed to the core |
| core_di_io | output | NUM_IO | Bidirectional pad values passed to the core |
| xcore_di | output | NUM_XPAD | Excluded pad values passed to the core |
| mac_tout | output | 1 | Shared memory-access / test-out pad value |

## Verification
The hardest case to reach from the ports is a fault on one particular pin. The test output must fall when exactly one covered pin is low, and it must not react to any excluded pin. A random pattern almost always has several low bits, so it hides which pin did the work. The stimulus therefore walks a single 0 across every covered pad, with all other covered pads held at 1. It then walks a single 0, and a single 1, across every excluded pad with the covered pads all high. Both walks are repeated with the core output enables fully asserted, which shows that the tri-state forcing wins over the core.

// File: rtl/pad_conn_pkg.sv
package pad_conn_pkg;

    typedef enum logic {
        MODE_FUNC = 1'b0,
        MODE_CONN = 1'b1
    } pad_mode_e;

endpackage

// File: rtl/pad_conn_and_tree.sv
module pad_conn_and_tree #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] leaf_i,
    output logic             all_high_o
);
    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node;

    // Leaves sit at the bottom of a heap-ordered tree; unused leaves read 1.
    genvar li;
    generate
        for (li = 0; li < LEAVES; li++) begin : g_leaf
            if (li < WIDTH) begin : g_used
                assign node[LEAVES-1+li] = leaf_i[li];
            end else begin : g_pad
                assign node[LEAVES-1+li] = 1'b1;
            end
        end
    endgenerate

    genvar ni;
    generate
        for (ni = 0; ni < LEAVES - 1; ni++) begin : g_node
            assign node[ni] = node[2*ni+1] & node[2*ni+2];
        end
    endgenerate

    assign all_high_o = node[0];

    // R5
    always_comb begin
        tree_match_chk: assert (all_high_o == (&leaf_i));
    end
endmodule

// File: rtl/pad_conn_gate.sv
module pad_conn_gate #(
    parameter int NUM_PAD = 10
) (
    input  logic               conn_mode_i,
    input  logic [NUM_PAD-1:0] core_do_i,
    input  logic [NUM_PAD-1:0] core_oe_i,
    output logic [NUM_PAD-1:0] pad_do_o,
    output logic [NUM_PAD-1:0] pad_oe_o
);
    genvar pi;
    generate
        for (pi = 0; pi < NUM_PAD; pi++) begin : g_pad
            assign pad_do_o[pi] = core_do_i[pi];
            assign pad_oe_o[pi] = core_oe_i[pi] & ~conn_mode_i;
        end
    endgenerate

    // R2
    always_comb begin
        if (conn_mode_i) begin
            tristate_chk: assert (pad_oe_o == '0);
        end
    end
endmodule

// File: rtl/pad_conn_test.sv
module pad_conn_test
    import pad_conn_pkg::*;
#(
    parameter int NUM_IN   = 6,
    parameter int NUM_IO   = 10,
    parameter int NUM_XPAD = 17
) (
    input  logic                     test_en_n,
    input  logic                     mem_sel,
    input  logic [NUM_IO-1:0]        core_do,
    input  logic [NUM_IO-1:0]        core_oe,
    input  logic [NUM_IN-1:0]        pad_di_in,
    input  logic [NUM_IO-1:0]        pad_di_io,
    input  logic [NUM_XPAD-1:0]      xpad_di,
    output logic [NUM_IO-1:0]        pad_do,
    output logic [NUM_IO-1:0]        pad_oe,
    output logic [NUM_IN+NUM_IO-1:0] pad_pu,
    output logic [NUM_IN-1:0]        core_di_in,
    output logic [NUM_IO-1:0]        core_di_io,
    output logic [NUM_XPAD-1:0]      xcore_di,
    output logic                     mac_tout
);
    localparam int NUM_COV = NUM_IN + NUM_IO;

    pad_mode_e          mode;
    logic               conn_mode;
    logic [NUM_COV-1:0] cov_di;
    logic               tree_out;

    // Mode selection: enter-test on test_en_n low, leave-test on high.
    always_comb begin
        mode = test_en_n ? MODE_FUNC : MODE_CONN;
    end

    assign conn_mode = (mode == MODE_CONN);
    assign cov_di    = {pad_di_io, pad_di_in};

    pad_conn_gate #(.NUM_PAD(NUM_IO)) u_gate (
        .conn_mode_i (conn_mode),
        .core_do_i   (core_do),
        .core_oe_i   (core_oe),
        .pad_do_o    (pad_do),
        .pad_oe_o    (pad_oe)
    );

    pad_conn_and_tree #(.WIDTH(NUM_COV)) u_tree (
        .leaf_i     (cov_di),
        .all_high_o (tree_out)
    );

    assign core_di_in = pad_di_in;
    assign core_di_io = pad_di_io;
    assign xcore_di   = xpad_di;

    // Output process per mode.
    always_comb begin
        unique case (mode)
            MODE_CONN: begin
                pad_pu   = '1;
                mac_tout = tree_out;
            end
            MODE_FUNC: begin
                pad_pu   = '0;
                mac_tout = mem_sel;
            end
            default: begin
                pad_pu   = '0;
                mac_tout = mem_sel;
            end
        endcase
    end

    // R1
    always_comb begin
        mode_sel_chk: assert ((mode == MODE_CONN) == !test_en_n);
    end

    // R2
    always_comb begin
        if (!test_en_n) begin
            no_drive_chk: assert (pad_oe == '0);
        end
    end

    // R3
    always_comb begin
        if (test_en_n) begin
            oe_pass_chk: assert (pad_oe == core_oe);
        end
    end

    // R4
    always_comb begin
        pull_chk: assert (pad_pu == (test_en_n ? '0 : '1));
    end

    // R6
    always_comb begin
        if (!test_en_n && ($countones(~{pad_di_io, pad_di_in}) != 0)) begin
            low_pull_chk: assert (mac_tout == 1'b0);
        end
    end

    // R8
    always_comb begin
        if (test_en_n) begin
            func_mac_chk: assert (mac_tout == mem_sel);
        end
    end
endmodule

// File: tb/tb_pad_conn_test.sv
module tb_pad_conn_test;
    localparam int NIN = 6;
    localparam int NIO = 10;
    localparam int NX  = 17;
    localparam int NCOV = NIN + NIO;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            test_en_n;
    logic            mem_sel;
    logic [NIO-1:0]  core_do, core_oe;
    logic [NIN-1:0]  pad_di_in;
    logic [NIO-1:0]  pad_di_io;
    logic [NX-1:0]   xpad_di;
    logic [NIO-1:0]  pad_do, pad_oe;
    logic [NCOV-1:0] pad_pu;
    logic [NIN-1:0]  core_di_in;
    logic [NIO-1:0]  core_di_io;
    logic [NX-1:0]   xcore_di;
    logic            mac_tout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pad_conn_test #(.NUM_IN(NIN), .NUM_IO(NIO), .NUM_XPAD(NX)) dut (
        .test_en_n (test_en_n),
        .mem_sel   (mem_sel),
        .core_do   (core_do),
        .core_oe   (core_oe),
        .pad_di_in (pad_di_in),
        .pad_di_io (pad_di_io),
        .xpad_di   (xpad_di),
        .pad_do    (pad_do),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .core_di_in(core_di_in),
        .core_di_io(core_di_io),
        .xcore_di  (xcore_di),
        .mac_tout  (mac_tout)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic ten, input logic ms, input logic [NIO-1:0] d,
                         input logic [NIO-1:0] oe, input logic [NCOV-1:0] cov,
                         input logic [NX-1:0] x);
        @(posedge clk);
        test_en_n = ten;
        mem_sel   = ms;
        core_do   = d;
        core_oe   = oe;
        pad_di_in = cov[NIN-1:0];
        pad_di_io = cov[NCOV-1:NIN];
        xpad_di   = x;
        @(negedge clk);
    endtask

    // Full expectation from the requirements for the current stimulus.
    task automatic check_all(input string tag);
        logic [NCOV-1:0] cov;
        logic exp_mac;
        cov = {pad_di_io, pad_di_in};
        exp_mac = test_en_n ? mem_sel : (&cov);
        check({tag, " R5 R6 R8 mac_tout"}, 64'(mac_tout), 64'(exp_mac));
        check({tag, " R2 R3 pad_oe"}, 64'(pad_oe), test_en_n ? 64'(core_oe) : 64'd0);
        check({tag, " R3 pad_do"}, 64'(pad_do), 64'(core_do));
        check({tag, " R4 pad_pu"}, 64'(pad_pu), test_en_n ? 64'd0 : 64'((1 << NCOV) - 1));
        check({tag, " R9 core_di"}, 64'({core_di_io, core_di_in}), 64'(cov));
        check({tag, " R7 xcore_di"}, 64'(xcore_di), 64'(xpad_di));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NCOV-1:0] ones;
        ones = '1;
        test_en_n = 1'b1; mem_sel = 1'b0; core_do = '0; core_oe = '0;
        pad_di_in = '1; pad_di_io = '1; xpad_di = '0;
        @(negedge clk);
        // Initial functional state (R1, R4, R8)
        check("R1 initial pad_pu", 64'(pad_pu), 64'd0);
        check("R8 initial mac_tout", 64'(mac_tout), 64'd0);

        // Functional mode: mem_sel both ways, pad inputs varied (R3, R8)
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 8; k++) begin
                apply(1'b1, m[0], NIO'($urandom), NIO'($urandom), NCOV'($urandom), NX'($urandom));
                check_all("func");
            end
        end

        // Enter test mode with all covered pads pulled high (R1, R5)
        apply(1'b0, 1'b0, '1, '1, ones, '0);
        check("R5 all-high test-out", 64'(mac_tout), 64'd1);
        check_all("conn-idle");

        // Single-low walk over every covered pad, both oe settings (R6, R2)
        for (int oe = 0; oe < 2; oe++) begin
            for (int i = 0; i < NCOV; i++) begin
                logic [NCOV-1:0] pat;
                pat = ones;
                pat[i] = 1'b0;
                apply(1'b0, 1'b1, NIO'($urandom), oe[0] ? '1 : '0, pat, NX'($urandom));
                check("R6 single-low walk", 64'(mac_tout), 64'd0);
                check_all("walk");
            end
        end

        // Excluded pads: walking 0 and walking 1 with covered pads high (R7)
        for (int v = 0; v < 2; v++) begin
            for (int j = 0; j < NX; j++) begin
                logic [NX-1:0] xp;
                xp = v[0] ? '0 : '1;
                xp[j] = v[0];
                apply(1'b0, 1'b0, '0, '1, ones, xp);
                check("R7 excluded pad ignored", 64'(mac_tout), 64'd1);
                check_all("excl");
            end
        end

        // Random multi-bit patterns in test mode (R5)
        for (int k = 0; k < 64; k++) begin
            apply(1'b0, k[0], NIO'($urandom), NIO'($urandom), NCOV'($urandom | $urandom), NX'($urandom));
            check_all("conn-rand");
        end

        // Leave test mode: shared pad returns to mem_sel at once (R1, R8)
        apply(1'b1, 1'b1, '0, '1, '0, '1);
        check("R1 leave-test mac_tout", 64'(mac_tout), 64'd1);
        check("R1 leave-test pad_oe", 64'(pad_oe), 64'((1 << NIO) - 1));
        check_all("exit");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule